// File: doc/BRIEF.md
# Carrier and Tone Detect Qualifier

This block sits behind the level comparator of a low-speed modem receive path. It takes a per-cycle flag that says whether in-band energy is above the detect threshold, and it turns that flag into a debounced, active-low detect output. The flag has to hold steadily for a qualification time before the output asserts. It has to stay absent for a release time before the output deasserts. Both times are counted in milliseconds from a tick that the block divides down from its own clock. They are chosen by the receive mode and by a 2-bit time code.

While nothing is qualified, the block clamps the receive-data output high, so that line noise cannot produce false data bits. In DTMF receive mode it captures the 4-bit tone code at the moment the detect output falls, and it holds that code until the next qualification. In transmit-side modes the detect and data outputs are parked high. In the power-down mode, the output enable is dropped so that the pad drivers can be tri-stated.

Top module: `tone_detect_qual`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset in mode 0, `det_n_o` and `rxd_o` read 1, `tone_o` reads 0 and `out_en_o` reads 1.
- R2: In FSK mode (`mode_i` = 0), the qualify/release delays in ms for `tcode_i` 0, 1, 2 and 3 are 450/35, 10/35, 10/20 and 70/15.
- R3: In DTMF receive mode (`mode_i` = 1), `tcode_i` 1, 2 and 3 give 25/25, 30/35 and 40/25 ms; code 0 behaves as code 1.
- R4: In call-progress mode (`mode_i` = 2), the delays are 10 ms to qualify and 25 ms to release, whatever `tcode_i` is.
- R5: Only an unbroken run counts. A single sample at the other level restarts the run. `det_n_o` changes at the clock edge on which the run reaches delay × CLK_PER_MS consecutive samples.
- R6: `det_n_o` is active low. It falls after a qualifying run of `energy_i` = 1 and rises after a releasing run of `energy_i` = 0.
- R7: While `det_n_o` is 1, `rxd_o` is 1. In FSK mode, while `det_n_o` is 0, `rxd_o` follows `rxd_raw_i`. In every other mode `rxd_o` is 1.
- R8: In DTMF receive mode, `tone_o` takes the value of `tone_code_i` sampled on the edge where `det_n_o` falls. It is unchanged at every other time and in every other mode.
- R9: For `mode_i` 3, 5, 6 and 7, `det_n_o` and `rxd_o` are 1 and `out_en_o` is 1. For `mode_i` 4, `det_n_o` and `rxd_o` are 1 and `out_en_o` is 0.
- R10: Any change of `mode_i` or `tcode_i` sends `det_n_o` high on the next edge and restarts the running count.
- R11: One millisecond equals CLK_PER_MS clock cycles. The divider restarts together with the run count, so the timing is exact to the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Receive mode: 0 FSK, 1 DTMF receive, 2 call progress, 4 power-down, other values transmit-side |
| tcode_i | input | 2 | Detect time code |
| energy_i | input | 1 | Raw energy-above-threshold flag |
| rxd_raw_i | input | 1 | Demodulated data before gating |
| tone_code_i | input | TONE_W | Decoded DTMF tone code |
| det_n_o | output | 1 | Qualified detect, active low |
| rxd_o | output | 1 | Gated receive data |
| tone_o | output | TONE_W | Tone code captured at qualification |
| out_en_o | output | 1 | Output drive enable, low in power-down |

## Verification
The embedded properties check the following on every cycle:
- the receive-data clamp while the detect output is high;
- the parked outputs in non-listening modes;
- the forced release after a configuration change;
- that the detect state only moves on a millisecond tick;
- the minimum spacing between ticks;
- that the captured tone is held between qualifications.

The exact qualify and release latencies for each mode and code, the restart after a glitch, and the tone value captured at the falling edge can only be shown by the bench. It runs directed threshold runs of one cycle short and exactly long enough, and it compares randomized energy bursts cycle by cycle against its own model of the delay tables.

// File: rtl/tdq_pkg.sv
package tdq_pkg;

   localparam int MAX_DELAY_MS = 450;
   localparam int DLY_W        = $clog2(MAX_DELAY_MS + 1);

   localparam logic [2:0] MD_FSK   = 3'd0;
   localparam logic [2:0] MD_DTMF  = 3'd1;
   localparam logic [2:0] MD_CPT   = 3'd2;
   localparam logic [2:0] MD_PDOWN = 3'd4;

   function automatic logic is_listening(input logic [2:0] md);
      return (md == MD_FSK) || (md == MD_DTMF) || (md == MD_CPT);
   endfunction

   // Delay in ms; rel selects the release (absent) delay.
   function automatic logic [DLY_W-1:0] delay_ms(input logic [2:0] md,
                                                 input logic [1:0] cd,
                                                 input logic       rel);
      int on_v;
      int off_v;
      on_v  = MAX_DELAY_MS;
      off_v = MAX_DELAY_MS;
      case (md)
         MD_FSK: begin
            case (cd)
               2'd0:    begin on_v = 450; off_v = 35; end
               2'd1:    begin on_v = 10;  off_v = 35; end
               2'd2:    begin on_v = 10;  off_v = 20; end
               default: begin on_v = 70;  off_v = 15; end
            endcase
         end
         MD_DTMF: begin
            case (cd)
               2'd2:    begin on_v = 30; off_v = 35; end
               2'd3:    begin on_v = 40; off_v = 25; end
               default: begin on_v = 25; off_v = 25; end
            endcase
         end
         MD_CPT: begin
            on_v  = 10;
            off_v = 25;
         end
         default: begin
            on_v  = MAX_DELAY_MS;
            off_v = MAX_DELAY_MS;
         end
      endcase
      return rel ? DLY_W'(off_v) : DLY_W'(on_v);
   endfunction

endpackage

// File: rtl/tdq_ms_tick.sv
module tdq_ms_tick #(
   parameter int CLK_PER_MS = 3580
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   localparam int              CNT_W = $clog2(CLK_PER_MS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_MS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr_i)         cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = !clr_i && (cnt_q == LAST);

   // R11
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

endmodule

// File: rtl/tdq_qualifier.sv
module tdq_qualifier
   import tdq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_i,
   input  logic [1:0] tcode_i,
   input  logic       energy_i,
   input  logic       tick_i,
   output logic       clr_o,
   output logic       det_o,
   output logic       det_rise_o
);
   localparam int CFG_W = 5;

   logic [CFG_W-1:0] cfg_q;
   logic [DLY_W-1:0] ms_q;
   logic [DLY_W-1:0] ms_nxt;
   logic [DLY_W-1:0] target;
   logic             det_q;
   logic             cfg_chg;
   logic             pending;
   logic             done;

   assign cfg_chg = ({mode_i, tcode_i} != cfg_q);
   assign pending = is_listening(mode_i) && (energy_i != det_q);
   assign target  = delay_ms(mode_i, tcode_i, det_q);
   assign ms_nxt  = ms_q + 1'b1;
   assign done    = tick_i && (ms_nxt == target);
   assign clr_o   = cfg_chg || !pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         det_q <= 1'b0;
         ms_q  <= '0;
      end else begin
         cfg_q <= {mode_i, tcode_i};
         if (cfg_chg) begin
            det_q <= 1'b0;
            ms_q  <= '0;
         end else if (!pending) begin
            ms_q  <= '0;
         end else if (tick_i) begin
            if (done) begin
               det_q <= ~det_q;
               ms_q  <= '0;
            end else begin
               ms_q  <= ms_nxt;
            end
         end
      end
   end

   assign det_o      = det_q;
   assign det_rise_o = done && !det_q && !cfg_chg;

   // R10
   cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> !det_q);

   // R5
   tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !cfg_chg) |=> $stable(det_q));

   // R2
   ms_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_chg |-> (ms_q < target));

endmodule

// File: rtl/tdq_out_stage.sv
module tdq_out_stage
   import tdq_pkg::*;
#(
   parameter int TONE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic              det_i,
   input  logic              det_rise_i,
   input  logic              rxd_raw_i,
   input  logic [TONE_W-1:0] tone_code_i,
   output logic              det_n_o,
   output logic              rxd_o,
   output logic [TONE_W-1:0] tone_o,
   output logic              out_en_o
);
   logic [TONE_W-1:0] tone_q;
   logic              capture;
   logic              listen;

   assign listen  = is_listening(mode_i);
   assign capture = det_rise_i && (mode_i == MD_DTMF);

   always_ff @(posedge clk) begin
      if (!rst_n)       tone_q <= '0;
      else if (capture) tone_q <= tone_code_i;
   end

   assign det_n_o  = listen ? ~det_i : 1'b1;
   assign rxd_o    = ((mode_i == MD_FSK) && det_i) ? rxd_raw_i : 1'b1;
   assign tone_o   = tone_q;
   assign out_en_o = (mode_i != MD_PDOWN);

   // R7
   rxd_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det_n_o |-> rxd_o);

   // R9
   parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !listen |-> (det_n_o && rxd_o));

   // R8
   tone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(tone_o));

endmodule

// File: rtl/tone_detect_qual.sv
module tone_detect_qual #(
   parameter int CLK_PER_MS = 3580,
   parameter int TONE_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic [1:0]        tcode_i,
   input  logic              energy_i,
   input  logic              rxd_raw_i,
   input  logic [TONE_W-1:0] tone_code_i,
   output logic              det_n_o,
   output logic              rxd_o,
   output logic [TONE_W-1:0] tone_o,
   output logic              out_en_o
);
   if (CLK_PER_MS < 2) begin : g_bad_div
      $error("tone_detect_qual: CLK_PER_MS must be 2 or more");
   end
   if (TONE_W < 1) begin : g_bad_tone
      $error("tone_detect_qual: TONE_W must be 1 or more");
   end

   logic tick;
   logic clr;
   logic det;
   logic det_rise;

   tdq_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .tick_o (tick)
   );

   tdq_qualifier u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode_i),
      .tcode_i    (tcode_i),
      .energy_i   (energy_i),
      .tick_i     (tick),
      .clr_o      (clr),
      .det_o      (det),
      .det_rise_o (det_rise)
   );

   tdq_out_stage #(.TONE_W(TONE_W)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode_i),
      .det_i       (det),
      .det_rise_i  (det_rise),
      .rxd_raw_i   (rxd_raw_i),
      .tone_code_i (tone_code_i),
      .det_n_o     (det_n_o),
      .rxd_o       (rxd_o),
      .tone_o      (tone_o),
      .out_en_o    (out_en_o)
   );

endmodule

// File: tb/tb_tone_detect_qual.sv
`timescale 1ns/1ps
module tb_tone_detect_qual;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'd0;
   logic [1:0] tcode = 2'd0;
   logic       energy = 1'b0;
   logic       rxd_raw = 1'b0;
   logic [3:0] tone = 4'd0;
   logic       det_n, rxd, oe;
   logic [3:0] tone_q;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc++;

   tone_detect_qual #(.CLK_PER_MS(N), .TONE_W(4)) dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .tcode_i(tcode),
      .energy_i(energy), .rxd_raw_i(rxd_raw), .tone_code_i(tone),
      .det_n_o(det_n), .rxd_o(rxd), .tone_o(tone_q), .out_en_o(oe)
   );

   // Delay tables from R2, R3, R4
   function automatic int on_ms(input logic [2:0] m, input logic [1:0] c);
      if (m == 3'd0) return (c == 0) ? 450 : (c == 3) ? 70 : 10;
      if (m == 3'd1) return (c == 2) ? 30 : (c == 3) ? 40 : 25;
      if (m == 3'd2) return 10;
      return 10;
   endfunction
   function automatic int off_ms(input logic [2:0] m, input logic [1:0] c);
      if (m == 3'd0) return (c == 2) ? 20 : (c == 3) ? 15 : 35;
      if (m == 3'd1) return (c == 2) ? 35 : 25;
      if (m == 3'd2) return 25;
      return 10;
   endfunction
   function automatic bit listening(input logic [2:0] m);
      return m <= 3'd2;
   endfunction
   function automatic string req_of(input logic [2:0] m);
      if (m == 3'd0) return "R2";
      if (m == 3'd1) return "R3";
      if (m == 3'd2) return "R4";
      return "R9";
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // Reference model (R5, R6, R8, R10, R11)
   bit       m_det;
   int       m_cnt;
   bit [4:0] m_cfg;
   bit [3:0] m_tone;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_det = 0; m_cnt = 0; m_cfg = 0; m_tone = 0;
      end else begin
         if ({mode, tcode} != m_cfg) begin
            m_det = 0; m_cnt = 0;
         end else if (listening(mode) && (energy != m_det)) begin
            if (m_cnt + 1 == (m_det ? off_ms(mode, tcode) : on_ms(mode, tcode)) * N) begin
               if (!m_det && mode == 3'd1) m_tone = tone;
               m_det = !m_det;
               m_cnt = 0;
            end else m_cnt++;
         end else m_cnt = 0;
         m_cfg = {mode, tcode};
      end
   end

   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n && !done_flag) begin
         check(req_of(mode), "det_n model", det_n, listening(mode) ? !m_det : 1);
         check("R7", "rxd model", rxd, (mode == 3'd0 && m_det) ? rxd_raw : 1);
         check("R8", "tone model", tone_q, m_tone);
         check("R9", "out_en model", oe, mode != 3'd4);
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rand_cycles(input int n);
      repeat (n) begin
         @(negedge clk);
         rxd_raw = 1'($urandom);
         tone = 4'($urandom);
      end
   endtask

   task automatic finish_run();
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2718));
      wait_n(3);
      // R1 during reset
      check("R1", "det_n in reset", det_n, 1);
      check("R1", "rxd in reset", rxd, 1);
      check("R1", "tone in reset", tone_q, 0);
      check("R1", "out_en in reset", oe, 1);
      rst_n = 1;
      wait_n(1);
      check("R1", "det_n after reset", det_n, 1);

      // R2 / R6 / R11: FSK code 1, qualify 10 ms = 40 cycles
      tcode = 2'd1;
      wait_n(2);
      energy = 1;
      wait_n(10 * N - 1);
      check("R2", "det_n one short of qualify", det_n, 1);
      wait_n(1);
      check("R6", "det_n at qualify", det_n, 0);
      // R7: data passes while detected
      rxd_raw = 0;
      #1 check("R7", "rxd follows raw", rxd, 0);
      // R5: glitch restarts the 35 ms release
      energy = 0;
      wait_n(100);
      energy = 1;
      wait_n(1);
      energy = 0;
      wait_n(35 * N - 1);
      check("R5", "det_n held after glitch", det_n, 0);
      wait_n(1);
      check("R11", "det_n at release", det_n, 1);
      check("R7", "rxd clamped", rxd, 1);

      // R3 / R8: DTMF code 0 behaves as 25/25
      mode = 3'd1; tcode = 2'd0; tone = 4'hA;
      wait_n(3);
      energy = 1;
      wait_n(25 * N - 1);
      check("R3", "det_n one short (code 0)", det_n, 1);
      check("R8", "tone before capture", tone_q, 0);
      wait_n(1);
      check("R3", "det_n at qualify (code 0)", det_n, 0);
      check("R8", "tone captured", tone_q, 4'hA);
      check("R7", "rxd high in DTMF", rxd, 1);
      tone = 4'h5;
      wait_n(5);
      check("R8", "tone held", tone_q, 4'hA);

      // R10: time code change releases at once
      tcode = 2'd1;
      wait_n(1);
      check("R10", "det_n after cfg change", det_n, 1);
      check("R8", "tone kept after release", tone_q, 4'hA);

      // R4: call progress
      energy = 0; mode = 3'd2; tcode = 2'd3;
      wait_n(2);
      energy = 1;
      wait_n(10 * N - 1);
      check("R4", "cpt one short", det_n, 1);
      wait_n(1);
      check("R4", "cpt qualified", det_n, 0);
      check("R8", "tone not captured in CPT", tone_q, 4'hA);

      // R9: parked and power-down
      mode = 3'd4;
      wait_n(200);
      check("R9", "det_n in power-down", det_n, 1);
      check("R9", "rxd in power-down", rxd, 1);
      check("R9", "out_en in power-down", oe, 0);
      mode = 3'd5;
      wait_n(200);
      check("R9", "det_n in transmit mode", det_n, 1);
      check("R9", "out_en in transmit mode", oe, 1);

      // Random bursts compared cycle by cycle against the model
      for (int s = 0; s < 40 && cyc < 140000; s++) begin
         int r;
         int lon;
         int loff;
         r = $urandom_range(0, 9);
         @(negedge clk);
         mode = (r < 4) ? 3'd0 : (r < 7) ? 3'd1 : (r == 7) ? 3'd2 :
                (r == 8) ? 3'($urandom_range(5, 7)) : 3'd4;
         tcode = 2'($urandom);
         energy = 0;
         lon  = on_ms(mode, tcode) * N;
         loff = off_ms(mode, tcode) * N;
         for (int b = 0; b < 4; b++) begin
            energy = 1;
            rand_cycles($urandom_range(1, lon + lon / 8 + 2));
            energy = 0;
            rand_cycles($urandom_range(1, loff + loff / 8 + 2));
         end
      end
      wait_n(2);
      finish_run();
   end
endmodule